// File: doc/BRIEF.md
# Processor reset vector sequencer

This block brings up the architectural register state of a small 32-bit microcontroller core after reset is released. It does not load fixed constants. It fetches two words from a vector table in memory, always in the same order, over a single-request memory read port. The first word becomes the main stack pointer. The second word becomes the program counter and supplies the execution-state T bit.

While the sequence runs, the block forces the stack pointers to word alignment and strips the state bit from the entry address. It sets the link register to all ones, clears the exception number, the if-then state and the four mask/control registers, and places the core in thread mode. If the entry word has bit 0 clear, the block raises a sticky error flag. The core is expected to act on the error after the sequence ends. When the values are final, a one-cycle `done` pulse tells the core it may start fetching.

The sequence is a state machine with seven states, which are also its transitions:
- IDLE moves unconditionally to READ_SP.
- READ_SP issues the first request and moves to WAIT_SP.
- WAIT_SP waits for a response and then moves to READ_PC.
- READ_PC issues the second request and moves to WAIT_PC.
- WAIT_PC waits for a response and then moves to INIT.
- INIT loads the remaining registers and moves to DONE.
- DONE is terminal until the next reset.

Top module: `rstvec_seq`

## Requirements
- R1: After reset release, `mem_req` is high for exactly one cycle with `mem_addr` equal to the table base (parameter `VT_BASE`). No further request is made until a response has been accepted.
- R2: The first response word is loaded into `msp` with bits [1:0] forced to 0.
- R3: After the first response, one single-cycle request is made at `VT_BASE + 4`. The second response word is loaded into `pc` with bit 0 forced to 0.
- R4: `tbit` equals bit 0 of the second word. If that bit is 0, `vec_err` goes high and stays high until reset.
- R5: At `done`, `lr` is 0xFFFFFFFF.
- R6: At `done`, `psp` equals `psp_in` (as sampled in INIT) with bits [1:0] forced to 0.
- R7: At `done`, `exc_num`, `it_state`, `primask`, `faultmask`, `basepri` and `control` are all 0, and `thread_mode` is 1.
- R8: `done` is high for exactly one cycle: the second clock edge after the edge that accepts the second response. It stays low after that until a new reset sequence completes.
- R9: `mem_rvalid` is ignored outside the two wait states. A response offered in IDLE, READ_SP, READ_PC or DONE changes neither `msp` nor `pc`.
- R10: While `rst_n` is low, `mem_req`, `done` and `vec_err` are 0, and every register output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | 32 | Read address (valid with `mem_req`) |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| psp_in | input | 32 | Current process stack pointer value |
| msp | output | 32 | Main stack pointer |
| psp | output | 32 | Process stack pointer, word aligned |
| lr | output | 32 | Link register |
| pc | output | 32 | Program counter |
| tbit | output | 1 | Execution-state T bit |
| exc_num | output | 9 | Current exception number |
| it_state | output | 8 | If-then execution state (both halves) |
| primask | output | 1 | Priority mask |
| faultmask | output | 1 | Fault mask |
| basepri | output | 8 | Base priority |
| control | output | 2 | Control register |
| thread_mode | output | 1 | 1 when the core is in thread mode |
| vec_err | output | 1 | Sticky invalid-entry-word flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches several properties on every cycle:
- Request pulses are single cycles, and every request address is one of the two table slots.
- `msp` and `pc` never leave alignment.
- `vec_err` is sticky, and `done` is a lone pulse.
- At `done`, the link register, mode and mask registers hold their initial values and the error flag agrees with `tbit`.

Other behaviour only the bench scenarios can show:
- The exact values taken from memory, and the exact cycle in which `done` fires relative to the response.
- That junk responses offered outside the wait states leave the registers untouched.
- That the error flag clears only through reset.

// File: rtl/rv_pkg.sv
package rv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_SP,
        ST_WAIT_SP,
        ST_READ_PC,
        ST_WAIT_PC,
        ST_INIT,
        ST_DONE
    } rv_state_e;

    localparam int EXC_W  = 9;
    localparam int IT_W   = 8;
    localparam int PRI_W  = 8;
    localparam int CTL_W  = 2;

endpackage

// File: rtl/rv_fsm.sv
module rv_fsm
    import rv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rvalid,
    output logic      req,
    output logic      sel_pc,
    output logic      cap_sp,
    output logic      cap_pc,
    output logic      do_init,
    output logic      done
);

    rv_state_e state_q, state_d;
    logic      done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_READ_SP;
            ST_READ_SP: state_d = ST_WAIT_SP;
            ST_WAIT_SP: if (rvalid) state_d = ST_READ_PC;
            ST_READ_PC: state_d = ST_WAIT_PC;
            ST_WAIT_PC: if (rvalid) state_d = ST_INIT;
            ST_INIT:    state_d = ST_DONE;
            ST_DONE:    state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_INIT);
        end
    end

    always_comb begin
        req     = 1'b0;
        sel_pc  = 1'b0;
        cap_sp  = 1'b0;
        cap_pc  = 1'b0;
        do_init = 1'b0;
        unique case (state_q)
            ST_READ_SP: req = 1'b1;
            ST_WAIT_SP: cap_sp = rvalid;
            ST_READ_PC: begin
                req    = 1'b1;
                sel_pc = 1'b1;
            end
            ST_WAIT_PC: begin
                sel_pc = 1'b1;
                cap_pc = rvalid;
            end
            ST_INIT:    do_init = 1'b1;
            default:    ;
        endcase
        done = done_q;
    end

endmodule

// File: rtl/rv_vecload.sv
module rv_vecload #(
    parameter int DATA_W   = 32,
    parameter int SP_ALIGN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_sp,
    input  logic              cap_pc,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] msp,
    output logic [DATA_W-1:0] pc,
    output logic              tbit,
    output logic              vec_err
);

    localparam logic [DATA_W-1:0] SP_MASK = ~((DATA_W'(1) << SP_ALIGN) - DATA_W'(1));
    localparam logic [DATA_W-1:0] PC_MASK = ~DATA_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msp     <= '0;
            pc      <= '0;
            tbit    <= 1'b0;
            vec_err <= 1'b0;
        end else begin
            if (cap_sp) msp <= rdata & SP_MASK;
            if (cap_pc) begin
                pc   <= rdata & PC_MASK;
                tbit <= rdata[0];
                if (!rdata[0]) vec_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rv_sysregs.sv
module rv_sysregs
    import rv_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SP_ALIGN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_init,
    input  logic [DATA_W-1:0] psp_in,
    output logic [DATA_W-1:0] psp,
    output logic [DATA_W-1:0] lr,
    output logic [EXC_W-1:0]  exc_num,
    output logic [IT_W-1:0]   it_state,
    output logic              primask,
    output logic              faultmask,
    output logic [PRI_W-1:0]  basepri,
    output logic [CTL_W-1:0]  control,
    output logic              thread_mode
);

    localparam logic [DATA_W-1:0] LR_INIT = '1;

    // Keep the upper bits of the process stack pointer and zero the alignment bits.
    logic [DATA_W-1:0] psp_aligned;
    genvar b;
    generate
        for (b = 0; b < DATA_W; b++) begin : g_psp
            if (b < SP_ALIGN) begin : g_lo
                assign psp_aligned[b] = 1'b0;
            end else begin : g_hi
                assign psp_aligned[b] = psp_in[b];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psp         <= '0;
            lr          <= '0;
            exc_num     <= '0;
            it_state    <= '0;
            primask     <= 1'b0;
            faultmask   <= 1'b0;
            basepri     <= '0;
            control     <= '0;
            thread_mode <= 1'b0;
        end else if (do_init) begin
            psp         <= psp_aligned;
            lr          <= LR_INIT;
            exc_num     <= '0;
            it_state    <= '0;
            primask     <= 1'b0;
            faultmask   <= 1'b0;
            basepri     <= '0;
            control     <= '0;
            thread_mode <= 1'b1;
        end
    end

endmodule

// File: rtl/rstvec_seq.sv
module rstvec_seq
    import rv_pkg::*;
#(
    parameter logic [31:0] VT_BASE  = 32'h0000_0000,
    parameter int          SP_ALIGN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic [31:0]       psp_in,
    output logic [31:0]       msp,
    output logic [31:0]       psp,
    output logic [31:0]       lr,
    output logic [31:0]       pc,
    output logic              tbit,
    output logic [EXC_W-1:0]  exc_num,
    output logic [IT_W-1:0]   it_state,
    output logic              primask,
    output logic              faultmask,
    output logic [PRI_W-1:0]  basepri,
    output logic [CTL_W-1:0]  control,
    output logic              thread_mode,
    output logic              vec_err,
    output logic              done
);

    localparam logic [31:0] SP_SLOT = VT_BASE;
    localparam logic [31:0] PC_SLOT = VT_BASE + 32'd4;

    logic sel_pc, cap_sp, cap_pc, do_init;

    rv_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rvalid  (mem_rvalid),
        .req     (mem_req),
        .sel_pc  (sel_pc),
        .cap_sp  (cap_sp),
        .cap_pc  (cap_pc),
        .do_init (do_init),
        .done    (done)
    );

    assign mem_addr = sel_pc ? PC_SLOT : SP_SLOT;

    rv_vecload #(.DATA_W(32), .SP_ALIGN(SP_ALIGN)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_sp  (cap_sp),
        .cap_pc  (cap_pc),
        .rdata   (mem_rdata),
        .msp     (msp),
        .pc      (pc),
        .tbit    (tbit),
        .vec_err (vec_err)
    );

    rv_sysregs #(.DATA_W(32), .SP_ALIGN(SP_ALIGN)) u_sys (
        .clk         (clk),
        .rst_n       (rst_n),
        .do_init     (do_init),
        .psp_in      (psp_in),
        .psp         (psp),
        .lr          (lr),
        .exc_num     (exc_num),
        .it_state    (it_state),
        .primask     (primask),
        .faultmask   (faultmask),
        .basepri     (basepri),
        .control     (control),
        .thread_mode (thread_mode)
    );

endmodule

// File: rtl/rv_chk.sv
module rv_chk
    import rv_pkg::*;
#(
    parameter logic [31:0] VT_BASE = 32'h0000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [31:0]       mem_addr,
    input logic [31:0]       msp,
    input logic [31:0]       psp,
    input logic [31:0]       lr,
    input logic [31:0]       pc,
    input logic              tbit,
    input logic [EXC_W-1:0]  exc_num,
    input logic [IT_W-1:0]   it_state,
    input logic              primask,
    input logic              faultmask,
    input logic [PRI_W-1:0]  basepri,
    input logic [CTL_W-1:0]  control,
    input logic              thread_mode,
    input logic              vec_err,
    input logic              done
);

    // R1
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R1
    req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == VT_BASE || mem_addr == VT_BASE + 32'd4));

    // R2
    msp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msp[1:0] == 2'b00);

    // R3
    pc_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc[0] == 1'b0);

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_err |=> vec_err);

    // R4
    err_tbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vec_err == !tbit));

    // R5
    lr_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lr == 32'hFFFF_FFFF));

    // R6
    psp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (psp[1:0] == 2'b00));

    // R7
    sysreg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (thread_mode && exc_num == '0 && it_state == '0 && !primask
                  && !faultmask && basepri == '0 && control == '0));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

bind rstvec_seq rv_chk #(.VT_BASE(VT_BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .msp         (msp),
    .psp         (psp),
    .lr          (lr),
    .pc          (pc),
    .tbit        (tbit),
    .exc_num     (exc_num),
    .it_state    (it_state),
    .primask     (primask),
    .faultmask   (faultmask),
    .basepri     (basepri),
    .control     (control),
    .thread_mode (thread_mode),
    .vec_err     (vec_err),
    .done        (done)
);

// File: tb/sim_rstvec_seq.sv
module sim_rstvec_seq;

    localparam logic [31:0] BASE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] psp_in = '0;
    logic [31:0] msp, psp, lr, pc;
    logic        tbit;
    logic [8:0]  exc_num;
    logic [7:0]  it_state;
    logic        primask, faultmask;
    logic [7:0]  basepri;
    logic [1:0]  control;
    logic        thread_mode, vec_err, done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    rstvec_seq #(.VT_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .psp_in(psp_in),
        .msp(msp), .psp(psp), .lr(lr), .pc(pc), .tbit(tbit),
        .exc_num(exc_num), .it_state(it_state), .primask(primask),
        .faultmask(faultmask), .basepri(basepri), .control(control),
        .thread_mode(thread_mode), .vec_err(vec_err), .done(done)
    );

    function automatic logic [31:0] exp_msp(input logic [31:0] w);
        return w & 32'hFFFF_FFFC;
    endfunction

    function automatic logic [31:0] exp_pc(input logic [31:0] w);
        return w & 32'hFFFF_FFFE;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] sp_w, input logic [31:0] pc_w,
                       input logic [31:0] psp_v, input int lat, input bit spur);
        logic [31:0] junk;
        junk = 32'h5A5A_A5A5 ^ sp_w ^ pc_w;
        rst_n = 1'b0;
        mem_rvalid = 1'b0;
        psp_in = psp_v;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!mem_req && !done && !vec_err, "R10 ctl", {29'd0, mem_req, done, vec_err}, 32'd0);
        chk(msp == 0 && pc == 0 && lr == 0 && psp == 0 && !thread_mode, "R10 regs", lr, 32'd0);
        rst_n = 1'b1;
        if (spur) begin mem_rvalid = 1'b1; mem_rdata = junk; end
        @(negedge clk);
        mem_rvalid = 1'b0;
        // R1 first request at base
        chk(mem_req && mem_addr == BASE, "R1 addr", mem_addr, BASE);
        // R9 IDLE response ignored
        chk(msp == 0, "R9 idle", msp, 32'd0);
        @(negedge clk);
        chk(!mem_req, "R1 pulse", {31'd0, mem_req}, 32'd0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(!mem_req, "R1 wait", {31'd0, mem_req}, 32'd0);
        end
        mem_rvalid = 1'b1; mem_rdata = sp_w;
        @(negedge clk);
        chk(msp == exp_msp(sp_w), "R2 msp", msp, exp_msp(sp_w));
        chk(mem_req && mem_addr == BASE + 32'd4, "R3 addr", mem_addr, BASE + 32'd4);
        if (spur) mem_rdata = junk; else mem_rvalid = 1'b0;
        @(negedge clk);
        mem_rvalid = 1'b0;
        // R9 response offered in READ_PC ignored
        chk(pc == 0 && msp == exp_msp(sp_w), "R9 readpc", pc, 32'd0);
        for (int i = 0; i < lat; i++) @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = pc_w;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(pc == exp_pc(pc_w), "R3 pc", pc, exp_pc(pc_w));
        chk(tbit == pc_w[0], "R4 tbit", {31'd0, tbit}, {31'd0, pc_w[0]});
        chk(vec_err == !pc_w[0], "R4 err", {31'd0, vec_err}, {31'd0, !pc_w[0]});
        chk(!done, "R8 early", {31'd0, done}, 32'd0);
        psp_in = psp_v;
        @(negedge clk);
        chk(done, "R8 pulse", {31'd0, done}, 32'd1);
        chk(lr == 32'hFFFF_FFFF, "R5 lr", lr, 32'hFFFF_FFFF);
        chk(psp == exp_msp(psp_v), "R6 psp", psp, exp_msp(psp_v));
        chk(thread_mode && exc_num == 0 && it_state == 0 && !primask && !faultmask
            && basepri == 0 && control == 0, "R7 sys",
            {exc_num, it_state, basepri, control, primask, faultmask, thread_mode}, 32'd1);
        mem_rvalid = 1'b1; mem_rdata = junk;
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(!done, "R8 single", {31'd0, done}, 32'd0);
        // R9 response in DONE ignored
        chk(msp == exp_msp(sp_w) && pc == exp_pc(pc_w), "R9 done", pc, exp_pc(pc_w));
        repeat (2) @(negedge clk);
        chk(vec_err == !pc_w[0] && !done, "R4 sticky", {31'd0, vec_err}, {31'd0, !pc_w[0]});
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        run(32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFF, 0, 1'b0);
        run(32'h2000_1003, 32'h0000_0400, 32'h1234_5677, 3, 1'b1);
        run(32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_0003, 0, 1'b1);
        run(32'h2000_8000, 32'h0800_0101, 32'hDEAD_BEEF, 7, 1'b0);
        for (int k = 0; k < 24; k++) begin
            run($urandom, $urandom, $urandom, int'($urandom % 6), 1'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule